// File: doc/BRIEF.md
# Three-Channel Square-Wave Tone Mixer

This block makes three square-wave tone voices and sets the output level of each. A shared prescaler divides the clock by sixteen. Each voice then divides that tick rate by its own 12-bit period. The tone bit flips each time the count completes, so a half-cycle lasts sixteen times the period in clocks. A mixer register decides, for each voice, whether its tone and an external noise bit take part in gating the voice. A per-voice amplitude register either gives a fixed 4-bit level or passes an external 4-bit envelope level through.

Software writes the registers through a single-cycle write strobe carrying an address and a byte. The noise source, the envelope generator and the analog conversion live outside. The block only sees the noise bit and the envelope level as inputs, and it hands out three registered 4-bit levels. The two top bits of the mixer register are kept and driven out as direction controls for two general-purpose ports.

Top module: `tone_mixer_core`

## Requirements
- R1: A synchronous active-high reset clears every register and counter, so all three levels read 0 and both direction bits read 0.
- R2: Voice n (n = 0, 1, 2) takes the low 8 period bits from address 2n and the high 4 bits from the low nibble of address 2n+1. The upper nibble at address 2n+1 is ignored.
- R3: With its tone enabled, noise disabled and a fixed level of 15, a voice's level alternates between 15 and 0. Each half-cycle lasts 16 x P clocks, where P is the programmed period, and a period of 0 behaves as 1.
- R4: A new period written while a half-cycle is running leaves that half-cycle at the old length. The following half-cycle uses the new length.
- R5: The mixer register at address 7 holds active-low enables: bit n disables the tone of voice n and bit n+3 disables its noise. The gate of a voice is (tone OR tone_disable) AND (noise_in OR noise_disable), and the voice outputs 0 when the gate is 0.
- R6: A voice with both tone and noise disabled outputs its selected level continuously. An amplitude of 0 silences it.
- R7: Amplitude registers sit at address 8+n. Bit 4 set selects env_in as the level and ignores bits 3..0. Bit 4 clear selects bits 3..0 as the level.
- R8: Bits 6 and 7 of the mixer register appear on port_dir[0] and port_dir[1] one clock after the write, with 1 meaning output.
- R9: Writes to address 6 or to addresses 11..15 change no output.
- R10: A change on noise_in or env_in reaches the levels one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| noise_in | input | 1 | Shared noise bit |
| env_in | input | 4 | Envelope level |
| level_o | output | 12 | Levels, voice n in bits 4n+3..4n |
| port_dir | output | 2 | Direction bits for ports A and B |

## Verification
Register writes land on the clock edge after the strobe, and the level output adds one more register. The bench therefore samples levels two edges after a write, at a falling edge. It samples one edge after a change on noise_in or env_in, and direction bits one edge after their write. Tone timing is checked as the number of falling edges between successive level changes, which is 16 x P with no constant offset. The first interval after a period write is checked against the old period and the second against the new one. The random mixing runs use a long period while the tone state is fixed, so each expected level follows from the register values and inputs alone.

// File: rtl/tmix_pkg.sv
package tmix_pkg;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned LVL_W    = 4;
  localparam int unsigned AMP_W    = LVL_W + 1;
  localparam int unsigned MIX_ADDR = 7;
  localparam int unsigned AMP_BASE = 8;

  typedef struct packed {
    logic             use_env;
    logic [LVL_W-1:0] fixed_lvl;
  } amp_t;
endpackage

// File: rtl/tmix_prescale.sv
module tmix_prescale #(
  parameter int unsigned DIV = 16
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      tick  <= (cnt_q == LAST);
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  // one tick per DIV clocks: a tick is never followed by another at once
  p_tick_single_r3: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
  // the tick is seen just after the counter wrapped
  p_tick_at_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    tick |-> (cnt_q == '0));
endmodule

// File: rtl/tmix_tone_chan.sv
module tmix_tone_chan #(
  parameter int unsigned PER_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [PER_W-1:0] period,
  output logic             tone
);
  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] lim_q;
  logic [PER_W-1:0] eff_per;
  logic [PER_W:0]   cnt_next;

  assign eff_per  = (period == '0) ? PER_W'(1) : period;
  assign cnt_next = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      lim_q <= PER_W'(1);
      tone  <= 1'b0;
    end else if (tick) begin
      if (cnt_next >= {1'b0, lim_q}) begin
        cnt_q <= '0;
        lim_q <= eff_per;
        tone  <= ~tone;
      end else begin
        cnt_q <= cnt_next[PER_W-1:0];
      end
    end
  end

  // the tone only moves on a prescaler tick
  p_toggle_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(tone) |-> $past(tick));
  // the running count stays inside the latched half-cycle length
  p_count_in_range_r4: assert property (@(posedge clk) disable iff (rst)
    cnt_q < lim_q);
  // the latched length only changes when the tone flips
  p_limit_at_reload_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(lim_q) |-> !$stable(tone));
endmodule

// File: rtl/tmix_level_sel.sv
module tmix_level_sel
  import tmix_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tone,
  input  logic             noise,
  input  logic             tone_off,
  input  logic             noise_off,
  input  amp_t             amp,
  input  logic [LVL_W-1:0] env,
  output logic [LVL_W-1:0] level_q
);
  logic             gate;
  logic [LVL_W-1:0] pick;

  assign gate = (tone | tone_off) & (noise | noise_off);
  assign pick = amp.use_env ? env : amp.fixed_lvl;

  always_ff @(posedge clk) begin
    if (rst) level_q <= '0;
    else     level_q <= gate ? pick : '0;
  end

  // a zero amplitude register silences the voice
  p_zero_amp_silent_r6: assert property (@(posedge clk) disable iff (rst)
    (amp == '0) |=> (level_q == '0));
  // both sources disabled: the fixed level is held
  p_free_run_level_r6: assert property (@(posedge clk) disable iff (rst)
    (tone_off && noise_off && !amp.use_env) |=> (level_q == $past(amp.fixed_lvl)));
  // envelope mode follows the envelope input when the gate is open
  p_env_follow_r7: assert property (@(posedge clk) disable iff (rst)
    (amp.use_env && tone_off && noise_off) |=> (level_q == $past(env)));
  // an enabled tone that is low forces zero
  p_tone_gate_r5: assert property (@(posedge clk) disable iff (rst)
    (!tone_off && !tone) |=> (level_q == '0));
endmodule

// File: rtl/tone_mixer_core.sv
module tone_mixer_core
  import tmix_pkg::*;
#(
  parameter int unsigned NUM_CH  = 3,
  parameter int unsigned PER_W   = 12,
  parameter int unsigned PRE_DIV = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic                    noise_in,
  input  logic [LVL_W-1:0]        env_in,
  output logic [NUM_CH*LVL_W-1:0] level_o,
  output logic [1:0]              port_dir
);
  localparam int unsigned HI_W = PER_W - DATA_W;

  logic              tick;
  logic [DATA_W-1:0] mix_q;

  tmix_prescale #(.DIV(PRE_DIV)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  always_ff @(posedge clk) begin
    if (rst)
      mix_q <= '0;
    else if (wr_en && wr_addr == ADDR_W'(MIX_ADDR))
      mix_q <= wr_data;
  end

  assign port_dir = mix_q[7:6];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [DATA_W-1:0] lo_q;
    logic [HI_W-1:0]   hi_q;
    amp_t              amp_q;
    logic              tone;

    always_ff @(posedge clk) begin
      if (rst) begin
        lo_q  <= '0;
        hi_q  <= '0;
        amp_q <= '0;
      end else if (wr_en) begin
        if (wr_addr == ADDR_W'(2*c))          lo_q  <= wr_data;
        if (wr_addr == ADDR_W'(2*c + 1))      hi_q  <= wr_data[HI_W-1:0];
        if (wr_addr == ADDR_W'(AMP_BASE + c)) amp_q <= wr_data[AMP_W-1:0];
      end
    end

    tmix_tone_chan #(.PER_W(PER_W)) u_tone (
      .clk    (clk),
      .rst    (rst),
      .tick   (tick),
      .period ({hi_q, lo_q}),
      .tone   (tone)
    );

    tmix_level_sel u_lvl (
      .clk       (clk),
      .rst       (rst),
      .tone      (tone),
      .noise     (noise_in),
      .tone_off  (mix_q[c]),
      .noise_off (mix_q[c + NUM_CH]),
      .amp       (amp_q),
      .env       (env_in),
      .level_q   (level_o[c*LVL_W +: LVL_W])
    );
  end

  // direction bits follow a mixer write one clock later
  p_dir_update_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(MIX_ADDR)) |=> (port_dir == $past(wr_data[7:6])));
  // an unmapped address leaves the direction bits alone
  p_unmapped_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_addr == ADDR_W'(6) || wr_addr > ADDR_W'(AMP_BASE + NUM_CH - 1)))
      |=> $stable(port_dir));
endmodule

// File: tb/test_tone_mixer_core.sv
module test_tone_mixer_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        noise_in = 1'b0;
  logic [3:0]  env_in = '0;
  logic [11:0] level_o;
  logic [1:0]  port_dir;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit tone_s [3];

  tone_mixer_core i_tone_mixer_core (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .noise_in(noise_in), .env_in(env_in), .level_o(level_o), .port_dir(port_dir)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual cycle %0d expected below 190000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [3:0] lvl(input int ch);
    return level_o[ch*4 +: 4];
  endfunction

  function automatic logic [3:0] exp_lvl(input bit tone, input bit noise,
      input bit toff, input bit noff, input logic [4:0] amp, input logic [3:0] env);
    bit g = (tone | toff) & (noise | noff);
    if (!g) return 4'd0;
    return amp[4] ? env : amp[3:0];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  task automatic next_change(input int ch, output int n);
    logic [3:0] prev = lvl(ch);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (lvl(ch) == prev && n < 70000);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    int n;
    void'($urandom(32'h5eed_0042));
    do_reset();
    // R1: reset state
    for (int c = 0; c < 3; c++) chk("R1 level", lvl(c), 0);
    chk("R1 port_dir", port_dir, 0);

    // long periods, written before the first tick
    for (int c = 0; c < 3; c++) begin
      wr(4'(2*c), 8'hFF); wr(4'(2*c+1), 8'h0F);
    end
    for (int c = 0; c < 3; c++) wr(4'(8+c), 8'h0F);
    wr(4'd7, 8'h38);
    repeat (40) @(negedge clk);
    for (int c = 0; c < 3; c++) tone_s[c] = (lvl(c) != 0);

    // random mixing, tone state held by the long period
    for (int it = 0; it < 150; it++) begin
      logic [7:0] en = 8'($urandom);
      logic [4:0] amp [3];
      for (int c = 0; c < 3; c++) begin
        amp[c] = 5'($urandom);
        if (it % 10 == 0) amp[c] = '0;
        wr(4'(8+c), {3'b0, amp[c]});
      end
      wr(4'd7, en);
      noise_in = 1'($urandom);
      env_in   = 4'($urandom);
      settle();
      for (int c = 0; c < 3; c++)
        chk(amp[c][4] ? "R7 env/fixed select" : "R5 gate mix", lvl(c),
            exp_lvl(tone_s[c], noise_in, en[c], en[c+3], amp[c], env_in));
      chk("R8 port_dir", port_dir, en[7:6]);
      // R10: input change lands after one clock
      noise_in = ~noise_in;
      env_in   = env_in + 4'd5;
      @(negedge clk);
      for (int c = 0; c < 3; c++)
        chk("R10 input latency", lvl(c),
            exp_lvl(tone_s[c], noise_in, en[c], en[c+3], amp[c], env_in));
    end

    // R6: both disabled keeps the fixed level; zero amplitude silences
    wr(4'd7, 8'h3F); wr(4'd8, 8'h09); settle();
    chk("R6 free-running level", lvl(0), 9);
    wr(4'd8, 8'h00); settle();
    chk("R6 zero amplitude", lvl(0), 0);
    // R7: envelope mode ignores low bits
    env_in = 4'd3; wr(4'd9, 8'h1A); settle();
    chk("R7 envelope mode", lvl(1), 3);
    // R8 directed
    wr(4'd7, 8'hBF); @(negedge clk);
    chk("R8 dir after one clock", port_dir, 2);
    // R9: unmapped writes change nothing
    wr(4'd10, 8'h0C); settle();
    wr(4'd6, 8'h00); wr(4'd11, 8'hFF); wr(4'd15, 8'h00); settle();
    chk("R9 level a", lvl(0), 0);
    chk("R9 level b", lvl(1), 3);
    chk("R9 level c", lvl(2), 12);
    chk("R9 port_dir", port_dir, 2);

    // tone timing on a fresh start
    do_reset();
    noise_in = 1'b0;
    wr(4'd0, 8'h03); wr(4'd1, 8'h00);         // A: P=3
    wr(4'd2, 8'h00); wr(4'd3, 8'hA0);         // B: P=0 (upper nibble ignored)
    wr(4'd4, 8'h02); wr(4'd5, 8'hF1);         // C: P=0x102
    for (int c = 0; c < 3; c++) wr(4'(8+c), 8'h0F);
    wr(4'd7, 8'h38);
    next_change(0, n); next_change(0, n); next_change(0, n);
    chk("R3 voice A half-cycle", n, 48);
    next_change(1, n); next_change(1, n); next_change(1, n);
    chk("R3 period zero as one", n, 16);
    next_change(2, n); next_change(2, n); next_change(2, n);
    chk("R2 coarse low nibble only", n, 16*258);
    // R4: write right after a flip
    next_change(0, n);
    wr(4'd0, 8'h07);
    next_change(0, n);
    chk("R4 running half-cycle keeps old period", n + 1, 48);
    next_change(0, n);
    chk("R4 new period next half-cycle", n, 112);
    // R2: coarse write changes voice B's high bits
    wr(4'd3, 8'hF0); wr(4'd2, 8'h02);
    next_change(1, n); next_change(1, n); next_change(1, n);
    chk("R2 fine byte voice B", n, 32);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule